// File: doc/BRIEF.md
# SPI Register-Access Slave

This block connects an external SPI master to a byte-wide register file of up to 64 entries inside the chip. Each transfer opens with a command byte that carries the direction, a per-transfer auto-increment flag and a 6-bit register address. One or more data bytes follow. Writes reach the core as one-cycle strobes, one per completed byte. Reads fetch a byte over the core read port and shift it back to the master.

SPI inputs are synchronised to the system clock `clk_i` and their edges are detected there. Every SCL high phase and every SCL low phase must therefore last at least 6 system clock cycles. The clock idles high while chip-select is high. The master launches bits on the falling SCL edge and the slave samples them on the rising edge. A static configuration input selects one of two data-pin modes. In 4-wire mode read data goes out on a dedicated output. In 3-wire mode it goes back on the shared data-in pin, through its own output enable. The core read port is combinational: `reg_rdata_i` must be valid in the cycle in which `reg_re_o` is high.

Top module: `spi_regif`

## Requirements
- R1: While reset is held and right after it is released, `reg_we_o`, `reg_re_o`, `spi_sdo_oe_o` and `spi_sdi_oe_o` are all low.
- R2: Bits are sampled on the rising SCL edge, MSb first. The first command bit sent is the direction (1 = read, 0 = write), the second is the increment flag, and the next six are the address, MSb first. The command byte therefore reads {rw, inc, addr[5:0]}.
- R3: In a write transfer, each fully received data byte produces exactly one `reg_we_o` pulse, with the byte on `reg_wdata_o` and the target on `reg_addr_o`. Neither output enable rises during a write.
- R4: In a multi-byte write with inc = 1, successive bytes go to successive addresses, and the address wraps from 63 to 0. With inc = 0, every byte goes to the command address.
- R5: In a read, `reg_re_o` pulses once at the end of the command byte with the command address. The byte from `reg_rdata_i` is returned MSb first. The output enable turns on at the falling SCL edge that starts bit 8.
- R6: For each further read byte, `reg_re_o` pulses at the falling SCL edge that starts that byte. The address follows the rule of R4. No read strobe is issued after the last byte when chip-select rises.
- R7: With `three_wire_i` = 0, read data is driven on `spi_sdo_o` under `spi_sdo_oe_o`, and `spi_sdi_oe_o` stays low.
- R8: With `three_wire_i` = 1, read data is driven on `spi_sdi_o` under `spi_sdi_oe_o`, and `spi_sdo_oe_o` stays low.
- R9: Both output enables drop combinationally when `spi_cs_ni` rises, with no clock edge needed.
- R10: A data byte cut short by chip-select rising produces no write strobe, and the next transfer starts cleanly.
- R11: `reg_we_o` and `reg_re_o` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| three_wire_i | input | 1 | Data-pin mode: 0 = 4-wire, 1 = 3-wire |
| spi_cs_ni | input | 1 | Chip-select, active low |
| spi_scl_i | input | 1 | Serial clock from master |
| spi_sdi_i | input | 1 | Serial data in (shared pin in 3-wire mode) |
| spi_sdi_o | output | 1 | Read data for the shared pin in 3-wire mode |
| spi_sdi_oe_o | output | 1 | Drive enable for the shared pin |
| spi_sdo_o | output | 1 | Read data for the dedicated output in 4-wire mode |
| spi_sdo_oe_o | output | 1 | Drive enable for the dedicated output |
| reg_addr_o | output | 6 | Register address |
| reg_wdata_o | output | 8 | Register write data |
| reg_we_o | output | 1 | Write strobe, one cycle |
| reg_re_o | output | 1 | Read strobe, one cycle |
| reg_rdata_i | input | 8 | Register read data, valid while `reg_re_o` is high |

## Verification
The assertions check on every cycle the properties that hold for any traffic:
- strobe width and exclusivity;
- that the two output enables are never on together;
- that neither is on while chip-select is high;
- that no write strobe appears while an output is driven.

Only the bench scenarios can show the rest:
- command decoding;
- the address sequences with and without increment, including the wrap at 63;
- the exact bytes returned in each pin mode;
- the missing read strobe after the last byte;
- that a truncated byte is discarded and the next transfer still works.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ADDR_W  = 6;
  localparam int unsigned BIT_W   = $clog2(DATA_W);
  localparam int unsigned RW_POS  = DATA_W - 1;
  localparam int unsigned INC_POS = DATA_W - 2;
endpackage

// File: rtl/spi_regif_sync.sv
module spi_regif_sync #(
  parameter int unsigned W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/spi_regif_rx.sv
module spi_regif_rx
  import spi_regif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni_i,
  input  logic              scl_i,
  input  logic              sdi_i,
  output logic              active_o,
  output logic              scl_fall_o,
  output logic [BIT_W-1:0]  bit_idx_o,
  output logic              byte_done_o,
  output logic [DATA_W-1:0] byte_o
);
  logic [2:0] sync_q;
  logic cs_s, scl_s, sdi_s, scl_q, scl_rise;
  logic [BIT_W-1:0]  bit_idx_q;
  logic [DATA_W-1:0] rx_q, byte_q;
  logic byte_done_q;

  // bit0 cs, bit1 scl, bit2 sdi; same depth keeps data aligned to its edge
  spi_regif_sync #(.W(3), .RST_VAL(3'b011)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sdi_i, scl_i, cs_ni_i}),
    .q_o   (sync_q)
  );
  assign cs_s  = sync_q[0];
  assign scl_s = sync_q[1];
  assign sdi_s = sync_q[2];

  assign active_o   = ~cs_s;
  assign scl_rise   = ~scl_q & scl_s & active_o;
  assign scl_fall_o = scl_q & ~scl_s & active_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q       <= 1'b1;
      bit_idx_q   <= '0;
      rx_q        <= '0;
      byte_q      <= '0;
      byte_done_q <= 1'b0;
    end else begin
      scl_q       <= scl_s;
      byte_done_q <= 1'b0;
      if (!active_o) begin
        bit_idx_q <= '0;
      end else if (scl_rise) begin
        rx_q      <= {rx_q[DATA_W-2:0], sdi_s};
        bit_idx_q <= bit_idx_q + 1'b1;
        if (bit_idx_q == BIT_W'(DATA_W - 1)) begin
          byte_done_q <= 1'b1;
          byte_q      <= {rx_q[DATA_W-2:0], sdi_s};
        end
      end
    end
  end

  assign bit_idx_o   = bit_idx_q;
  assign byte_done_o = byte_done_q;
  assign byte_o      = byte_q;
endmodule

// File: rtl/spi_regif_ctrl.sv
module spi_regif_ctrl
  import spi_regif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              scl_fall_i,
  input  logic [BIT_W-1:0]  bit_idx_i,
  input  logic              byte_done_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o,
  output logic              re_o,
  output logic              tx_bit_o,
  output logic              oe_o
);
  logic cmd_done_q, rd_q, inc_q, first_q, oe_q, we_q, re_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_done_q <= 1'b0;
      rd_q       <= 1'b0;
      inc_q      <= 1'b0;
      first_q    <= 1'b0;
      oe_q       <= 1'b0;
      we_q       <= 1'b0;
      re_q       <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      tx_q       <= '0;
    end else begin
      we_q <= 1'b0;
      re_q <= 1'b0;
      if (re_q) tx_q <= rdata_i;
      // step after the strobe so the address stays put while it is high
      if (we_q && inc_q) addr_q <= addr_q + 1'b1;
      if (!active_i) begin
        cmd_done_q <= 1'b0;
        first_q    <= 1'b0;
        oe_q       <= 1'b0;
      end else begin
        if (byte_done_i) begin
          if (!cmd_done_q) begin
            cmd_done_q <= 1'b1;
            rd_q       <= byte_i[RW_POS];
            inc_q      <= byte_i[INC_POS];
            addr_q     <= byte_i[ADDR_W-1:0];
            re_q       <= byte_i[RW_POS];
            first_q    <= byte_i[RW_POS];
          end else if (!rd_q) begin
            we_q    <= 1'b1;
            wdata_q <= byte_i;
          end
        end
        if (scl_fall_i && cmd_done_q && rd_q) begin
          if (bit_idx_i != '0) begin
            tx_q <= {tx_q[DATA_W-2:0], 1'b0};
          end else if (first_q) begin
            first_q <= 1'b0;
            oe_q    <= 1'b1;
          end else begin
            // fetch the next byte only once the master clocks into it
            re_q <= 1'b1;
            if (inc_q) addr_q <= addr_q + 1'b1;
          end
        end
      end
    end
  end

  assign addr_o   = addr_q;
  assign wdata_o  = wdata_q;
  assign we_o     = we_q;
  assign re_o     = re_q;
  assign tx_bit_o = tx_q[DATA_W-1];
  assign oe_o     = oe_q;
endmodule

// File: rtl/spi_regif.sv
module spi_regif
  import spi_regif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              three_wire_i,
  input  logic              spi_cs_ni,
  input  logic              spi_scl_i,
  input  logic              spi_sdi_i,
  output logic              spi_sdi_o,
  output logic              spi_sdi_oe_o,
  output logic              spi_sdo_o,
  output logic              spi_sdo_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  logic active, scl_fall, byte_done, tx_bit, oe, drive;
  logic [BIT_W-1:0]  bit_idx;
  logic [DATA_W-1:0] rx_byte;

  spi_regif_rx i_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni_i    (spi_cs_ni),
    .scl_i      (spi_scl_i),
    .sdi_i      (spi_sdi_i),
    .active_o   (active),
    .scl_fall_o (scl_fall),
    .bit_idx_o  (bit_idx),
    .byte_done_o(byte_done),
    .byte_o     (rx_byte)
  );

  spi_regif_ctrl i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active),
    .scl_fall_i (scl_fall),
    .bit_idx_i  (bit_idx),
    .byte_done_i(byte_done),
    .byte_i     (rx_byte),
    .rdata_i    (reg_rdata_i),
    .addr_o     (reg_addr_o),
    .wdata_o    (reg_wdata_o),
    .we_o       (reg_we_o),
    .re_o       (reg_re_o),
    .tx_bit_o   (tx_bit),
    .oe_o       (oe)
  );

  // raw chip-select gates the drivers so release needs no clock
  assign drive        = oe & ~spi_cs_ni;
  assign spi_sdo_o    = tx_bit;
  assign spi_sdi_o    = tx_bit;
  assign spi_sdo_oe_o = drive & ~three_wire_i;
  assign spi_sdi_oe_o = drive & three_wire_i;
endmodule

// File: rtl/spi_regif_chk.sv
module spi_regif_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic spi_cs_ni,
  input logic spi_sdo_oe_o,
  input logic spi_sdi_oe_o,
  input logic reg_we_o,
  input logic reg_re_o
);
  a_r11_we_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);
  a_r11_re_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o);
  a_r11_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o));
  a_r8_one_driver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(spi_sdo_oe_o && spi_sdi_oe_o));
  a_r3_no_drive_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_sdo_oe_o || spi_sdi_oe_o) |-> !reg_we_o);
  a_r9_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_ni |-> !(spi_sdo_oe_o || spi_sdi_oe_o));
endmodule

bind spi_regif spi_regif_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .spi_cs_ni   (spi_cs_ni),
  .spi_sdo_oe_o(spi_sdo_oe_o),
  .spi_sdi_oe_o(spi_sdi_oe_o),
  .reg_we_o    (reg_we_o),
  .reg_re_o    (reg_re_o)
);

// File: tb/test_spi_regif.sv
module test_spi_regif;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 10;  // SCL half period in clk cycles

  typedef struct packed {
    logic        three;
    logic        rd;
    logic        inc;
    logic [5:0]  addr;
    logic [1:0]  nb;
    logic [23:0] data;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 6'h0B, 2'd1, 24'hA50000},
    '{1'b0, 1'b0, 1'b1, 6'h3E, 2'd3, 24'h112233},
    '{1'b0, 1'b0, 1'b0, 6'h10, 2'd2, 24'h5AC300},
    '{1'b0, 1'b1, 1'b0, 6'h00, 2'd1, 24'h000000},
    '{1'b0, 1'b1, 1'b1, 6'h3F, 2'd3, 24'h000000},
    '{1'b1, 1'b1, 1'b0, 6'h15, 2'd2, 24'h000000},
    '{1'b1, 1'b0, 1'b1, 6'h20, 2'd2, 24'h0FF0AA},
    '{1'b1, 1'b1, 1'b1, 6'h07, 2'd2, 24'h000000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic three_wire = 1'b0;
  logic spi_cs = 1'b1;
  logic spi_scl = 1'b1;
  logic spi_sdi = 1'b0;
  logic spi_sdi_o, spi_sdi_oe_o, spi_sdo_o, spi_sdo_oe_o;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic reg_we, reg_re;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [5:0] we_a [0:63];
  logic [7:0] we_d [0:63];
  logic [5:0] re_a [0:63];
  int we_n = 0, re_n = 0, sdo_cnt = 0, sdi_cnt = 0;

  function automatic logic [7:0] exp_rd(input logic [5:0] a);
    return {a, 2'b01} ^ 8'hC3;
  endfunction

  assign reg_rdata = exp_rd(reg_addr);

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regif i_spi_regif (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .three_wire_i(three_wire),
    .spi_cs_ni   (spi_cs),
    .spi_scl_i   (spi_scl),
    .spi_sdi_i   (spi_sdi),
    .spi_sdi_o   (spi_sdi_o),
    .spi_sdi_oe_o(spi_sdi_oe_o),
    .spi_sdo_o   (spi_sdo_o),
    .spi_sdo_oe_o(spi_sdo_oe_o),
    .reg_addr_o  (reg_addr),
    .reg_wdata_o (reg_wdata),
    .reg_we_o    (reg_we),
    .reg_re_o    (reg_re),
    .reg_rdata_i (reg_rdata)
  );

  always @(negedge clk) begin
    if (reg_we) begin
      we_a[we_n[5:0]] <= reg_addr;
      we_d[we_n[5:0]] <= reg_wdata;
      we_n <= we_n + 1;
    end
    if (reg_re) begin
      re_a[re_n[5:0]] <= reg_addr;
      re_n <= re_n + 1;
    end
    if (spi_sdo_oe_o) sdo_cnt <= sdo_cnt + 1;
    if (spi_sdi_oe_o) sdi_cnt <= sdi_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic spi_bit(input logic b, output logic m);
    spi_scl = 1'b0;
    spi_sdi = b;
    repeat (HALF) @(negedge clk);
    m = three_wire ? spi_sdi_o : spi_sdo_o;
    spi_scl = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    logic m;
    for (int i = 7; i >= 0; i--) begin
      spi_bit(tx[i], m);
      rx[i] = m;
    end
  endtask

  task automatic spi_xfer(input logic [7:0] cmd, input int nb, input logic [23:0] wd,
                          input bit hold, output logic [23:0] rd);
    logic [7:0] b;
    rd = '0;
    spi_cs = 1'b0;
    repeat (HALF) @(negedge clk);
    spi_byte(cmd, b);
    for (int i = 0; i < nb; i++) begin
      spi_byte(wd[23-8*i -: 8], b);
      rd[23-8*i -: 8] = b;
    end
    if (!hold) begin
      repeat (HALF) @(negedge clk);
      spi_cs = 1'b1;
      repeat (4*HALF) @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] rd;
    logic m;
    repeat (3) @(negedge clk);
    check(!reg_we && !reg_re, "R1", "strobes in reset", {reg_we, reg_re}, 0);
    check(!spi_sdo_oe_o && !spi_sdi_oe_o, "R1", "oe in reset",
          {spi_sdo_oe_o, spi_sdi_oe_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!reg_we && !reg_re && !spi_sdo_oe_o && !spi_sdi_oe_o, "R1", "idle after reset",
          {reg_we, reg_re, spi_sdo_oe_o, spi_sdi_oe_o}, 0);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      int we0, re0, sdo0, sdi0, nb;
      logic [5:0] ea;
      t = VECS[v];
      nb = int'(t.nb);
      three_wire = t.three;
      we0 = we_n; re0 = re_n; sdo0 = sdo_cnt; sdi0 = sdi_cnt;
      spi_xfer({t.rd, t.inc, t.addr}, nb, t.data, 1'b0, rd);
      if (!t.rd) begin
        check(we_n - we0 == nb, "R3", "write strobe count", we_n - we0, nb);
        check(re_n == re0, "R3", "no read strobe on write", re_n - re0, 0);
        check(sdo_cnt == sdo0 && sdi_cnt == sdi0, "R3", "no drive on write",
              (sdo_cnt - sdo0) + (sdi_cnt - sdi0), 0);
        for (int i = 0; i < nb; i++) begin
          ea = t.inc ? t.addr + 6'(i) : t.addr;
          check(we_a[6'(we0 + i)] == ea, "R4", "write address (R2 decode)",
                we_a[6'(we0 + i)], ea);
          check(we_d[6'(we0 + i)] == t.data[23-8*i -: 8], "R3", "write data",
                we_d[6'(we0 + i)], t.data[23-8*i -: 8]);
        end
      end else begin
        check(re_n - re0 == nb, "R6", "read strobe count", re_n - re0, nb);
        check(we_n == we0, "R5", "no write strobe on read", we_n - we0, 0);
        for (int i = 0; i < nb; i++) begin
          ea = t.inc ? t.addr + 6'(i) : t.addr;
          check(re_a[6'(re0 + i)] == ea, "R6", "read address (R2 decode)",
                re_a[6'(re0 + i)], ea);
          check(rd[23-8*i -: 8] == exp_rd(ea), "R5", "read data",
                rd[23-8*i -: 8], exp_rd(ea));
        end
        if (!t.three) begin
          check(sdo_cnt > sdo0 && sdi_cnt == sdi0, "R7", "4-wire drive select",
                {16'(sdo_cnt - sdo0), 16'(sdi_cnt - sdi0)}, 0);
        end else begin
          check(sdi_cnt > sdi0 && sdo_cnt == sdo0, "R8", "3-wire drive select",
                {16'(sdi_cnt - sdi0), 16'(sdo_cnt - sdo0)}, 0);
        end
      end
    end

    // R9: release with no clock edge between CS rise and the check
    three_wire = 1'b0;
    spi_xfer(8'h80 | 8'h12, 1, 24'h0, 1'b1, rd);
    check(spi_sdo_oe_o, "R9", "driving before CS rise", spi_sdo_oe_o, 1);
    check(rd[23:16] == exp_rd(6'h12), "R5", "held read data", rd[23:16], exp_rd(6'h12));
    repeat (HALF) @(negedge clk);
    spi_cs = 1'b1;
    #1;
    check(!spi_sdo_oe_o && !spi_sdi_oe_o, "R9", "released on CS rise",
          {spi_sdo_oe_o, spi_sdi_oe_o}, 0);
    repeat (4*HALF) @(negedge clk);

    // R10: partial data byte is dropped
    begin
      int we0;
      logic [7:0] b;
      we0 = we_n;
      spi_cs = 1'b0;
      repeat (HALF) @(negedge clk);
      spi_byte(8'h05, b);
      for (int i = 0; i < 4; i++) spi_bit(1'b1, m);
      spi_cs = 1'b1;
      repeat (4*HALF) @(negedge clk);
      check(we_n == we0, "R10", "no strobe for partial byte", we_n - we0, 0);
      spi_xfer(8'h05, 1, 24'h3C0000, 1'b0, rd);
      check(we_n - we0 == 1, "R10", "next transfer strobes", we_n - we0, 1);
      check(we_a[6'(we0)] == 6'h05 && we_d[6'(we0)] == 8'h3C, "R10", "next transfer content",
            {we_a[6'(we0)], we_d[6'(we0)]}, {6'h05, 8'h3C});
    end

    check(!reg_we && !reg_re, "R11", "strobes idle at end", {reg_we, reg_re}, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule